// File: doc/BRIEF.md
# DRAM Reset and Impedance Calibration Sequencer

This block sits on the controller side of a DRAM interface. It drives the memory's active-low reset line and issues long and short impedance-calibration commands. It counts the minimum reset-low times in clocks. A configuration input gives the number of clocks per microsecond, and every time is rounded up to whole clocks. The power-up reset is held for at least 200 µs. A reset requested by software after initialization is held for at least 100 ns. After either kind of reset, the block waits for a single "mode registers loaded" handshake, which stands in for mode-register programming. It then issues the first long calibration and holds it for a 512-clock window. Only after that window has fully elapsed does it report initialization done.

Once initialization is done, the command scheduler can ask for long calibrations, which use a 256-clock window, or short calibrations, which use a 64-clock window. A request is latched and held pending until the scheduler reports the DRAM idle and no window is open. It is then issued as a one-cycle command pulse, and the busy flag covers the whole window. A software reset taken after initialization aborts any open window, drops all pending requests and forces a full re-initialization.

Top module: `zq_rst_seq`

## Requirements
- R1: While `rst_ni` is low and afterwards, until a power-up request is taken, `dram_rst_no` is 0, `busy_o` is 1, `init_done_o` is 0, `mr_load_o` is 0, and both command outputs are 0.
- R2: A power-up request taken while powered off holds `dram_rst_no` low for exactly 200 × `clk_per_us_i` clocks after the request edge, where a `clk_per_us_i` of 0 counts as 1. The line is then released.
- R3: In the cycle the reset line is released, `mr_load_o` goes to 1. It stays at 1, with no calibration command issued, until `mr_done_i` is sampled high.
- R4: The cycle after `mr_done_i` is sampled, `zq_long_o` pulses for one cycle whatever `sched_idle_i` is. `busy_o` stays high for 512 cycles starting with the pulse, and `init_done_o` rises in the following cycle.
- R5: After initialization, a long-calibration request gives a one-cycle `zq_long_o` pulse, and `busy_o` stays high for 256 cycles starting with the pulse.
- R6: After initialization, a short-calibration request gives a one-cycle `zq_short_o` pulse, and `busy_o` stays high for 64 cycles starting with the pulse.
- R7: After initialization, a command is issued only at a clock edge where `sched_idle_i` is 1 and no window is open. A request that meets a non-idle scheduler or an open window is held pending, and its pulse appears in the cycle after the first edge that allows it. A request sampled at an edge that allows it appears in the next cycle.
- R8: When both kinds of request are pending, the long one is issued first. The short one follows at the first edge after the long window closes, and the two command outputs are never high together.
- R9: A software reset request taken while initialization is done (including during a calibration window) holds `dram_rst_no` low for exactly ceil(100 × `clk_per_us_i` / 1000) clocks, with 0 counting as 1. It clears `init_done_o`, discards pending requests and repeats the sequence of R3 and R4.
- R10: `pwrup_req_i` has no effect except when powered off, and `sw_rst_req_i` has no effect until initialization is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; returns the block to powered off |
| clk_per_us_i | input | CPU_W | Clocks per microsecond used for the reset-low minimums |
| pwrup_req_i | input | 1 | Power-up request |
| sw_rst_req_i | input | 1 | Software reset request |
| sched_idle_i | input | 1 | Scheduler reports the DRAM idle |
| zql_req_i | input | 1 | Long-calibration request |
| zqs_req_i | input | 1 | Periodic short-calibration request |
| mr_done_i | input | 1 | Mode registers loaded |
| dram_rst_no | output | 1 | Active-low DRAM reset line |
| mr_load_o | output | 1 | Mode-register load requested |
| zq_long_o | output | 1 | Long-calibration command pulse |
| zq_short_o | output | 1 | Short-calibration command pulse |
| busy_o | output | 1 | Reset, initialization or calibration window in progress |
| init_done_o | output | 1 | Initialization complete |

## Verification
The reset line falls or stays low from the cycle after a request edge, so the bench counts low samples from that cycle and expects exactly 200 × rate or the rounded-up 100 ns count. A command pulse is due one cycle after the edge that sees an allowing request, mr_done or idle transition, and the bench checks for it on that exact sample and for silence on every sample before it. The busy window is counted from the pulse sample up to the first sample with busy low, which must equal the window length. For the long-then-short case, the short pulse is expected one sample after that.

// File: rtl/zq_rst_seq_pkg.sv
package zq_rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_HOLD,
    ST_MRLOAD,
    ST_CAL_INIT,
    ST_READY,
    ST_CAL
  } seq_st_e;

  localparam int unsigned REQ_LONG  = 0;
  localparam int unsigned REQ_SHORT = 1;
  localparam int unsigned N_REQ     = 2;

endpackage

// File: rtl/rst_hold_calc.sv
module rst_hold_calc #(
  parameter int unsigned CPU_W     = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PWRUP_US  = 200,
  parameter int unsigned RT_RST_NS = 100
) (
  input  logic [CPU_W-1:0] cpu_i,
  output logic [CNT_W-1:0] pwr_cyc_o,
  output logic [CNT_W-1:0] rt_cyc_o
);

  logic [CPU_W-1:0] cpu_eff;
  logic [31:0]      pwr_w;
  logic [31:0]      rt_w;

  // a rate of zero would give a zero-length hold
  assign cpu_eff = (cpu_i == '0) ? CPU_W'(1) : cpu_i;
  assign pwr_w   = 32'(cpu_eff) * PWRUP_US;
  assign rt_w    = (32'(cpu_eff) * RT_RST_NS + 32'd999) / 32'd1000;

  assign pwr_cyc_o = CNT_W'(pwr_w);
  assign rt_cyc_o  = CNT_W'(rt_w);

endmodule

// File: rtl/win_cnt.sv
module win_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/zq_req_pend.sv
module zq_req_pend #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  input  logic         flush_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] pend_q;

  for (genvar g = 0; g < N; g++) begin : g_req
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pend_q[g] <= 1'b0;
      else if (flush_i) pend_q[g] <= 1'b0;
      else              pend_q[g] <= pend_o[g] & ~clr_i[g];
    end
    // a request is visible in the cycle it arrives
    assign pend_o[g] = pend_q[g] | req_i[g];
  end

endmodule

// File: rtl/zq_rst_seq.sv
module zq_rst_seq
  import zq_rst_seq_pkg::*;
#(
  parameter int unsigned CPU_W        = 8,
  parameter int unsigned PWRUP_US     = 200,
  parameter int unsigned RT_RST_NS    = 100,
  parameter int unsigned ZQ_INIT_CYC  = 512,
  parameter int unsigned ZQ_LONG_CYC  = 256,
  parameter int unsigned ZQ_SHORT_CYC = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CPU_W-1:0] clk_per_us_i,
  input  logic             pwrup_req_i,
  input  logic             sw_rst_req_i,
  input  logic             sched_idle_i,
  input  logic             zql_req_i,
  input  logic             zqs_req_i,
  input  logic             mr_done_i,
  output logic             dram_rst_no,
  output logic             mr_load_o,
  output logic             zq_long_o,
  output logic             zq_short_o,
  output logic             busy_o,
  output logic             init_done_o
);

  localparam int unsigned MAX_HOLD = PWRUP_US * ((1 << CPU_W) - 1);
  localparam int unsigned CNT_W_H  = $clog2(MAX_HOLD + 1);
  localparam int unsigned CNT_W_Z  = $clog2(ZQ_INIT_CYC + 1);
  localparam int unsigned CNT_W    = (CNT_W_H > CNT_W_Z) ? CNT_W_H : CNT_W_Z;

  seq_st_e          st_q, st_d;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_last;
  logic [CNT_W-1:0] pwr_cyc, rt_cyc;
  logic [N_REQ-1:0] req_vec, clr_vec, pend_vec;
  logic             ready, post_init, rst_take;
  logic             issue, issue_long, issue_short;
  logic             zq_long_q, zq_short_q;

  rst_hold_calc #(
    .CPU_W    (CPU_W),
    .CNT_W    (CNT_W),
    .PWRUP_US (PWRUP_US),
    .RT_RST_NS(RT_RST_NS)
  ) u_calc (
    .cpu_i    (clk_per_us_i),
    .pwr_cyc_o(pwr_cyc),
    .rt_cyc_o (rt_cyc)
  );

  win_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cnt_load),
    .val_i (cnt_val),
    .last_o(cnt_last)
  );

  always_comb begin
    req_vec            = '0;
    req_vec[REQ_LONG]  = zql_req_i;
    req_vec[REQ_SHORT] = zqs_req_i;
    clr_vec            = '0;
    clr_vec[REQ_LONG]  = issue_long;
    clr_vec[REQ_SHORT] = issue_short;
  end

  zq_req_pend #(.N(N_REQ)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_vec),
    .clr_i  (clr_vec),
    .flush_i(rst_take),
    .pend_o (pend_vec)
  );

  assign ready       = (st_q == ST_READY);
  assign post_init   = (st_q == ST_READY) || (st_q == ST_CAL);
  assign rst_take    = post_init && sw_rst_req_i;
  assign issue       = ready && !sw_rst_req_i && sched_idle_i && (|pend_vec);
  assign issue_long  = issue && pend_vec[REQ_LONG];
  assign issue_short = issue && !pend_vec[REQ_LONG];

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (st_q)
      ST_OFF: if (pwrup_req_i) begin
        st_d     = ST_HOLD;
        cnt_load = 1'b1;
        cnt_val  = pwr_cyc;
      end
      ST_HOLD:     if (cnt_last) st_d = ST_MRLOAD;
      ST_MRLOAD: if (mr_done_i) begin
        st_d     = ST_CAL_INIT;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(ZQ_INIT_CYC);
      end
      ST_CAL_INIT: if (cnt_last) st_d = ST_READY;
      ST_READY: begin
        if (rst_take) begin
          st_d     = ST_HOLD;
          cnt_load = 1'b1;
          cnt_val  = rt_cyc;
        end else if (issue) begin
          st_d     = ST_CAL;
          cnt_load = 1'b1;
          cnt_val  = issue_long ? CNT_W'(ZQ_LONG_CYC) : CNT_W'(ZQ_SHORT_CYC);
        end
      end
      ST_CAL: begin
        if (rst_take) begin
          st_d     = ST_HOLD;
          cnt_load = 1'b1;
          cnt_val  = rt_cyc;
        end else if (cnt_last) begin
          st_d = ST_READY;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_OFF;
      zq_long_q  <= 1'b0;
      zq_short_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      zq_long_q  <= ((st_q == ST_MRLOAD) && mr_done_i) || issue_long;
      zq_short_q <= issue_short;
    end
  end

  assign dram_rst_no = !((st_q == ST_OFF) || (st_q == ST_HOLD));
  assign mr_load_o   = (st_q == ST_MRLOAD);
  assign zq_long_o   = zq_long_q;
  assign zq_short_o  = zq_short_q;
  assign busy_o      = !ready;
  assign init_done_o = post_init;

endmodule

// File: rtl/zq_rst_seq_chk.sv
module zq_rst_seq_chk #(
  parameter int unsigned ZQ_INIT_CYC  = 512,
  parameter int unsigned ZQ_LONG_CYC  = 256,
  parameter int unsigned ZQ_SHORT_CYC = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sched_idle_i,
  input logic dram_rst_no,
  input logic mr_load_o,
  input logic zq_long_o,
  input logic zq_short_o,
  input logic busy_o,
  input logic init_done_o
);

  logic        in_cal_q, seen_ready_q;
  logic [31:0] len_q, exp_q;

  // window length tracked with a counter, not a deep $past
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cal_q     <= 1'b0;
      seen_ready_q <= 1'b0;
      len_q        <= '0;
      exp_q        <= '0;
    end else if (!dram_rst_no) begin
      in_cal_q     <= 1'b0;
      seen_ready_q <= 1'b0;
    end else begin
      if (init_done_o) seen_ready_q <= 1'b1;
      if (zq_long_o || zq_short_o) begin
        in_cal_q <= 1'b1;
        len_q    <= 32'd1;
        exp_q    <= zq_short_o ? ZQ_SHORT_CYC :
                    (seen_ready_q ? ZQ_LONG_CYC : ZQ_INIT_CYC);
      end else if (in_cal_q && busy_o) begin
        len_q <= len_q + 32'd1;
      end else if (in_cal_q) begin
        in_cal_q <= 1'b0;
      end
    end
  end

  a_r1_rst_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_rst_no |-> (busy_o && !init_done_o && !mr_load_o));

  a_r3_release_to_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_rst_no) |-> mr_load_o);

  a_r5_window_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_cal_q && !busy_o) |-> (len_q == exp_q));  // R4 R5 R6

  a_r7_short_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zq_short_o |-> $past(sched_idle_i));

  a_r7_long_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zq_long_o && $past(init_done_o)) |-> $past(sched_idle_i));

  a_r8_one_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(zq_long_o && zq_short_o));

endmodule

bind zq_rst_seq zq_rst_seq_chk #(
  .ZQ_INIT_CYC (ZQ_INIT_CYC),
  .ZQ_LONG_CYC (ZQ_LONG_CYC),
  .ZQ_SHORT_CYC(ZQ_SHORT_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sched_idle_i(sched_idle_i),
  .dram_rst_no (dram_rst_no),
  .mr_load_o   (mr_load_o),
  .zq_long_o   (zq_long_o),
  .zq_short_o  (zq_short_o),
  .busy_o      (busy_o),
  .init_done_o (init_done_o)
);

// File: tb/zq_rst_seq_tb_top.sv
module zq_rst_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CPU_W      = 8;
  localparam int WDOG       = 150000;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CPU_W-1:0] clk_per_us = '0;
  logic             pwrup_req = 1'b0, sw_rst_req = 1'b0, sched_idle = 1'b0;
  logic             zql_req = 1'b0, zqs_req = 1'b0, mr_done = 1'b0;
  logic             dram_rst_no, mr_load, zq_long, zq_short, busy, init_done;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zq_rst_seq dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .clk_per_us_i(clk_per_us),
    .pwrup_req_i (pwrup_req),
    .sw_rst_req_i(sw_rst_req),
    .sched_idle_i(sched_idle),
    .zql_req_i   (zql_req),
    .zqs_req_i   (zqs_req),
    .mr_done_i   (mr_done),
    .dram_rst_no (dram_rst_no),
    .mr_load_o   (mr_load),
    .zq_long_o   (zq_long),
    .zq_short_o  (zq_short),
    .busy_o      (busy),
    .init_done_o (init_done)
  );

  function automatic int exp_pwr(int c);
    return ((c == 0) ? 1 : c) * 200;
  endfunction

  function automatic int exp_rt(int c);
    int e = (c == 0) ? 1 : c;
    return (e * 100 + 999) / 1000;
  endfunction

  function automatic int exp_win(bit is_long);
    return is_long ? 256 : 64;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!dram_rst_no && n < 100000) begin
      n++;
      step();
    end
  endtask

  task automatic count_busy(output int n, output int extra);
    bit first = 1'b1;
    n = 0;
    extra = 0;
    while (busy && n < 100000) begin
      if (!first && (zq_long || zq_short)) extra++;
      first = 1'b0;
      n++;
      step();
    end
  endtask

  // current sample: reset line just released
  task automatic init_seq(string tag);
    int n, extra;
    chk(mr_load == 1'b1, {tag, " R3 load"}, int'(mr_load), 1);
    sched_idle = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(!zq_long && !zq_short && mr_load, {tag, " R3 wait"}, int'(zq_long | zq_short), 0);
      step();
    end
    mr_done = 1'b1;
    step();
    mr_done = 1'b0;
    chk(zq_long == 1'b1 && zq_short == 1'b0, {tag, " R4 pulse"}, int'(zq_long), 1);
    count_busy(n, extra);
    chk(n == 512, {tag, " R4 window"}, n, 512);
    chk(extra == 0, {tag, " R4 single pulse"}, extra, 0);
    chk(init_done == 1'b1, {tag, " R4 done"}, int'(init_done), 1);
  endtask

  task automatic powerup(int c);
    int n;
    rst_ni = 1'b0;
    repeat (3) step();
    chk(!dram_rst_no && busy && !init_done && !mr_load && !zq_long && !zq_short,
        "R1 reset state", int'(dram_rst_no), 0);
    rst_ni = 1'b1;
    step();
    sw_rst_req = 1'b1;
    step();
    sw_rst_req = 1'b0;
    step();
    chk(!dram_rst_no && !mr_load && busy, "R10 sw reset ignored when off", int'(mr_load), 0);
    chk(!init_done, "R1 off state", int'(init_done), 0);
    clk_per_us = CPU_W'(c);
    pwrup_req = 1'b1;
    step();
    pwrup_req = 1'b0;
    count_low(n);
    chk(n == exp_pwr(c), "R2 power-up hold", n, exp_pwr(c));
    sw_rst_req = 1'b1;
    step();
    sw_rst_req = 1'b0;
    chk(dram_rst_no && mr_load, "R10 sw reset ignored before init", int'(dram_rst_no), 1);
    init_seq("pwrup");
  endtask

  task automatic cal(bit is_long, int delay);
    int n, extra;
    sched_idle = (delay == 0);
    if (is_long) zql_req = 1'b1; else zqs_req = 1'b1;
    step();
    zql_req = 1'b0;
    zqs_req = 1'b0;
    for (int i = 0; i < delay; i++) begin
      chk(!zq_long && !zq_short && !busy, "R7 held while not idle", int'(zq_long | zq_short), 0);
      if (i == delay - 1) sched_idle = 1'b1;
      step();
    end
    if (is_long) chk(zq_long && !zq_short, "R5 long pulse", int'(zq_long), 1);
    else         chk(zq_short && !zq_long, "R6 short pulse", int'(zq_short), 1);
    count_busy(n, extra);
    chk(n == exp_win(is_long), is_long ? "R5 window" : "R6 window", n, exp_win(is_long));
    chk(extra == 0, "R8 single pulse", extra, 0);
    sched_idle = 1'($urandom % 2);
  endtask

  task automatic swreset(int c);
    int n;
    clk_per_us = CPU_W'(c);
    sw_rst_req = 1'b1;
    step();
    sw_rst_req = 1'b0;
    chk(!init_done, "R9 done cleared", int'(init_done), 0);
    count_low(n);
    chk(n == exp_rt(c), "R9 runtime hold", n, exp_rt(c));
    init_seq("swrst");
  endtask

  initial begin
    int n, extra, c;
    void'($urandom(32'h5eed_0017));
    step();
    powerup(0);

    // pwrup ignored after init
    pwrup_req = 1'b1;
    step();
    pwrup_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(dram_rst_no && init_done && !busy, "R10 pwrup ignored", int'(dram_rst_no), 1);
      step();
    end

    cal(1'b1, 0);
    cal(1'b0, 0);
    cal(1'b0, 4);
    cal(1'b1, 2);

    // both pending: long first, short right after
    sched_idle = 1'b0;
    zql_req = 1'b1;
    zqs_req = 1'b1;
    step();
    zql_req = 1'b0;
    zqs_req = 1'b0;
    step();
    chk(!zq_long && !zq_short, "R7 both held", int'(zq_long | zq_short), 0);
    sched_idle = 1'b1;
    step();
    chk(zq_long && !zq_short, "R8 long first", int'(zq_long), 1);
    count_busy(n, extra);
    chk(n == 256, "R8 long window", n, 256);
    step();
    chk(zq_short && !zq_long, "R8 short follows", int'(zq_short), 1);
    count_busy(n, extra);
    chk(n == 64, "R6 window after long", n, 64);

    // request during open window
    sched_idle = 1'b1;
    zql_req = 1'b1;
    step();
    zql_req = 1'b0;
    chk(zq_long, "R5 pulse", int'(zq_long), 1);
    zqs_req = 1'b1;
    step();
    zqs_req = 1'b0;
    count_busy(n, extra);
    chk(n == 255 && extra == 0, "R7 held while busy", n, 255);
    step();
    chk(zq_short, "R7 issued after window", int'(zq_short), 1);
    count_busy(n, extra);

    // abort during window, runtime rounding
    zqs_req = 1'b1;
    step();
    zqs_req = 1'b0;
    repeat (5) step();
    swreset(11);
    swreset(0);

    // pending flushed by reset
    sched_idle = 1'b0;
    zql_req = 1'b1;
    step();
    zql_req = 1'b0;
    swreset(25);
    sched_idle = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(!zq_long && !zq_short && !busy, "R9 pending discarded", int'(zq_long | zq_short), 0);
    end

    // second power-up, other rate
    powerup(7);

    for (int it = 0; it < 24; it++) begin
      if (it % 8 == 7) begin
        c = int'($urandom % 256);
        swreset(c);
      end else begin
        cal(1'($urandom % 2), int'($urandom % 6));
      end
    end
    swreset(255);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule